// File: doc/BRIEF.md
# Flash program and erase sequencer

This block sits between a processor's register bus and a flash array and controls when a program or erase may start. It has two registers. The control register selects one of three operations: a single-word program, a row program or a page erase. The key register can only be written, and it guards the start bit. Before software may set the start bit, it must write 0x0055 and then 0x00AA to the key register, with no other register write between the two. Each unlocked state covers exactly one start attempt.

When a start is accepted, the block checks that the target byte address is aligned for the chosen operation. It then raises a stall towards the processor and counts a fixed number of clock cycles, which stands in for the flash operation time. At the end it clears the start bit by itself and pulses a done output for one cycle. A start with a bad alignment or no operation selected is refused, and an error flag is set. The three operation lengths and the array geometry are parameters.

Top module: `nvm_seq`

## Requirements
- R1: The key register always reads 0. The control register reads bit 15 = operation running, bit 13 = error, bits 1:0 = operation code (00 none, 01 word, 10 row, 11 page erase), and all other bits 0.
- R2: An unlock needs a key write of 0x0055 followed directly by a key write of 0x00AA. Any other register write between those two writes cancels the unlock.
- R3: A control write with bit 15 set and no valid unlock does not start anything. Bit 15 stays 0, stall stays low and the error flag keeps its value. The operation code is still updated.
- R4: One start attempt uses up the unlock, whether the start is accepted or refused. The next operation needs a new key sequence.
- R5: Alignment rules: a word address must be a multiple of WORD_BYTES (3), a row address a multiple of ROW_BYTES (192), and a page address a multiple of ROW_BYTES*PAGE_ROWS (1536). An unlocked start with a misaligned address, or with code 00, starts nothing and sets bit 13.
- R6: An accepted start raises stall and bit 15 in the cycle after the write. Both stay high for exactly WORD_CYCLES, ROW_CYCLES or PAGE_CYCLES cycles, according to the operation.
- R7: Bit 15 clears by itself when the count ends. Done is high for exactly one cycle: the first cycle with stall low.
- R8: While an operation runs, writes to either register are ignored. The operation code is kept, and key writes do not advance the unlock.
- R9: An accepted start clears the error flag.
- R10: After reset the control register reads 0, stall and done are low, and the block is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select for writes: 0 control, 1 key |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Register select for reads: 0 control, 1 key |
| tgt_addr | input | ADDR_W | Target byte address of the operation |
| rd_data | output | 16 | Read data of the selected register (combinational) |
| stall | output | 1 | Processor stall, high while an operation runs |
| done | output | 1 | One-cycle pulse when an operation completes |

## Verification
Register writes take effect at the clock edge on which they are sampled. The bench therefore drives each write at a falling edge, removes it at the next falling edge, and only then reads the control register and stall. A started operation holds stall for exactly N cycles. The bench counts the falling edges on which stall is high, compares that count with the operation's parameter, and expects done on the first falling edge with stall low and no longer one edge later. Short cycle counts are passed to the bench instance so that every operation length can be counted exactly.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_WORD = 2'b01,
        OP_ROW  = 2'b10,
        OP_PAGE = 2'b11
    } nvm_op_e;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'b00,
        KEY_HALF   = 2'b01,
        KEY_ARMED  = 2'b10
    } key_state_e;

    localparam logic [15:0] KEY_FIRST  = 16'h0055;
    localparam logic [15:0] KEY_SECOND = 16'h00AA;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
    import nvm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    input  logic        busy,
    output logic        armed
);
    typedef struct packed {
        key_state_e st;
    } unl_t;

    unl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en && !busy) begin
            if (wr_sel) begin
                if (s_q.st == KEY_HALF)
                    s_d.st = (wr_data == KEY_SECOND) ? KEY_ARMED : KEY_LOCKED;
                else
                    s_d.st = (wr_data == KEY_FIRST) ? KEY_HALF : KEY_LOCKED;
            end else begin
                if (s_q.st == KEY_HALF)
                    s_d.st = KEY_LOCKED;
                else if (s_q.st == KEY_ARMED && wr_data[15])
                    s_d.st = KEY_LOCKED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: KEY_LOCKED};
        else        s_q <= s_d;
    end

    assign armed = (s_q.st == KEY_ARMED);

    // R2
    arm_after_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(wr_en && wr_sel && wr_data == KEY_SECOND));

    // R4
    unlock_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en && !wr_sel && wr_data[15] && !busy) |=> !armed);
endmodule

// File: rtl/nvm_align.sv
module nvm_align
    import nvm_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int WORD_BYTES = 3,
    parameter int ROW_BYTES  = 192,
    parameter int PAGE_ROWS  = 8
) (
    input  nvm_op_e             op,
    input  logic [ADDR_W-1:0]   addr,
    output logic                ok
);
    localparam int PAGE_BYTES = ROW_BYTES * PAGE_ROWS;

    logic word_ok, row_ok, page_ok;

    assign word_ok = (addr % ADDR_W'(WORD_BYTES)) == '0;
    assign row_ok  = (addr % ADDR_W'(ROW_BYTES))  == '0;
    assign page_ok = (addr % ADDR_W'(PAGE_BYTES)) == '0;

    always_comb begin
        unique case (op)
            OP_WORD: ok = word_ok;
            OP_ROW:  ok = row_ok;
            OP_PAGE: ok = page_ok;
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/nvm_timer.sv
module nvm_timer
    import nvm_pkg::*;
#(
    parameter int WORD_CYCLES = 1424,
    parameter int ROW_CYCLES  = 11064,
    parameter int PAGE_CYCLES = 44256
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    launch,
    input  nvm_op_e op,
    output logic    busy,
    output logic    done
);
    localparam int MAX_A  = (WORD_CYCLES > ROW_CYCLES) ? WORD_CYCLES : ROW_CYCLES;
    localparam int MAX_C  = (MAX_A > PAGE_CYCLES) ? MAX_A : PAGE_CYCLES;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        unique case (op)
            OP_WORD: load_val = CNT_W'(WORD_CYCLES - 1);
            OP_PAGE: load_val = CNT_W'(PAGE_CYCLES - 1);
            default: load_val = CNT_W'(ROW_CYCLES - 1);
        endcase
    end

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                t_d.busy = 1'b0;
                t_d.done = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end else if (launch) begin
            t_d.busy = 1'b1;
            t_d.cnt  = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{busy: 1'b0, done: 1'b0, cnt: '0};
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;
    assign done = t_q.done;

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.busy && t_q.cnt != '0) |=> (t_q.busy && t_q.cnt == $past(t_q.cnt) - 1'b1));

    // R7
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.done |-> (!t_q.busy && $past(t_q.busy)));
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int WORD_BYTES  = 3,
    parameter int ROW_BYTES   = 192,
    parameter int PAGE_ROWS   = 8,
    parameter int WORD_CYCLES = 1424,
    parameter int ROW_CYCLES  = 11064,
    parameter int PAGE_CYCLES = 44256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [15:0]       wr_data,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] tgt_addr,
    output logic [15:0]       rd_data,
    output logic              stall,
    output logic              done
);
    typedef struct packed {
        nvm_op_e op;
        logic    err;
    } ctl_t;

    ctl_t    c_d, c_q;
    logic    busy, armed, addr_ok, ctl_wr, start_try, launch;
    nvm_op_e new_op;
    logic    unused_bits;

    assign unused_bits = ^wr_data[14:2];
    assign new_op      = nvm_op_e'(wr_data[1:0]);
    assign ctl_wr      = wr_en && !wr_sel && !busy;
    assign start_try   = ctl_wr && wr_data[15];
    assign launch      = start_try && armed && addr_ok;

    nvm_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .busy    (busy),
        .armed   (armed)
    );

    nvm_align #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .ROW_BYTES  (ROW_BYTES),
        .PAGE_ROWS  (PAGE_ROWS)
    ) u_align (
        .op   (new_op),
        .addr (tgt_addr),
        .ok   (addr_ok)
    );

    nvm_timer #(
        .WORD_CYCLES (WORD_CYCLES),
        .ROW_CYCLES  (ROW_CYCLES),
        .PAGE_CYCLES (PAGE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .op     (new_op),
        .busy   (busy),
        .done   (done)
    );

    always_comb begin
        c_d = c_q;
        if (ctl_wr) c_d.op = new_op;
        if (start_try && armed) c_d.err = !addr_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{op: OP_NONE, err: 1'b0};
        else        c_q <= c_d;
    end

    assign stall   = busy;
    assign rd_data = rd_sel ? 16'h0000 : {busy, 1'b0, c_q.err, 11'b0, c_q.op};

    // R3
    locked_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_try && !armed) |=> !stall);

    // R5
    misalign_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_try && armed && !addr_ok) |=> (!stall && c_q.err));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> (c_q.op == $past(c_q.op)));

    // R9
    launch_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> !c_q.err);
endmodule

// File: tb/nvm_seq_tb.sv
module nvm_seq_tb;
    localparam int AW = 24;
    localparam int WC = 5;
    localparam int RC = 9;
    localparam int PC = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [15:0]   wr_data = '0;
    logic          rd_sel = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [15:0]   rd_data;
    logic          stall, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    nvm_seq #(
        .ADDR_W(AW), .WORD_CYCLES(WC), .ROW_CYCLES(RC), .PAGE_CYCLES(PC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .tgt_addr(tgt_addr), .rd_data(rd_data), .stall(stall), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(1'b1, 16'h0055);
        wr(1'b1, 16'h00AA);
    endtask

    task automatic read_ctl(output logic [15:0] v);
        rd_sel = 1'b0; #1; v = rd_data;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (stall && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        read_ctl(v);
        check("R10 ctl after reset", v, 0);
        check("R10 stall after reset", stall, 0);
        check("R10 done after reset", done, 0);
        rd_sel = 1'b1; #1;
        check("R1 key reads zero", rd_data, 0);
        rd_sel = 1'b0;
    endtask

    task automatic t_op(input string req, input logic [1:0] op, input int addr, input int expn);
        logic [15:0] v;
        int n;
        tgt_addr = AW'(addr);
        unlock();
        wr(1'b0, 16'h8000 | 16'(op));
        read_ctl(v);
        check({req, " R6 bit15 set while running"}, v[15], 1);
        check({req, " R1 op readback"}, v[1:0], op);
        wait_idle(n);
        check({req, " R6 stall length"}, n, expn);
        check({req, " R7 done pulse"}, done, 1);
        read_ctl(v);
        check({req, " R7 bit15 self-clear"}, v[15], 0);
        @(negedge clk);
        check({req, " R7 done one cycle"}, done, 0);
    endtask

    task automatic t_no_unlock();
        logic [15:0] v;
        tgt_addr = '0;
        wr(1'b0, 16'h8002);
        read_ctl(v);
        check("R3 no start without unlock", stall, 0);
        check("R3 ctl readback", v, 16'h0002);
    endtask

    task automatic t_broken();
        logic [15:0] v;
        tgt_addr = AW'(192);
        wr(1'b1, 16'h0055);
        wr(1'b0, 16'h0002);
        wr(1'b1, 16'h00AA);
        wr(1'b0, 16'h8002);
        @(negedge clk);
        check("R2 control write cancels unlock", stall, 0);
        wr(1'b1, 16'h0055);
        wr(1'b1, 16'h0011);
        wr(1'b1, 16'h00AA);
        wr(1'b0, 16'h8002);
        read_ctl(v);
        check("R2 wrong key cancels unlock", stall, 0);
        check("R2 nothing started bit15", v[15], 0);
    endtask

    task automatic t_misalign();
        logic [15:0] v;
        tgt_addr = AW'(100);
        unlock();
        wr(1'b0, 16'h8002);
        read_ctl(v);
        check("R5 row misaligned no stall", stall, 0);
        check("R5 row misaligned err", v[13], 1);
        tgt_addr = AW'(192);
        wr(1'b0, 16'h8002);
        read_ctl(v);
        check("R4 unlock consumed", stall, 0);
        check("R4 err kept", v[13], 1);
        tgt_addr = AW'(4);
        unlock();
        wr(1'b0, 16'h8001);
        read_ctl(v);
        check("R5 word misaligned", {stall, v[13]}, 1);
        tgt_addr = AW'(192);
        unlock();
        wr(1'b0, 16'h8003);
        read_ctl(v);
        check("R5 page misaligned", {stall, v[13]}, 1);
        tgt_addr = '0;
        unlock();
        wr(1'b0, 16'h8000);
        read_ctl(v);
        check("R5 op none refused", {stall, v[13]}, 1);
    endtask

    task automatic t_clear_err();
        logic [15:0] v;
        int n;
        tgt_addr = AW'(6);
        unlock();
        wr(1'b0, 16'h8001);
        read_ctl(v);
        check("R9 accepted start clears err", {stall, v[13]}, 2);
        wait_idle(n);
        check("R9 word length", n, WC);
    endtask

    task automatic t_busy_writes();
        logic [15:0] v;
        int n;
        tgt_addr = AW'(384);
        unlock();
        wr(1'b0, 16'h8002);
        wr(1'b0, 16'h0001);
        wr(1'b1, 16'h0055);
        rd_sel = 1'b1; #1;
        check("R1 key reads zero while busy", rd_data, 0);
        rd_sel = 1'b0;
        wait_idle(n);
        read_ctl(v);
        check("R8 op kept over busy write", v[1:0], 2);
        wr(1'b1, 16'h00AA);
        wr(1'b0, 16'h8002);
        @(negedge clk);
        check("R8 key during busy ignored", stall, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_unlock();
        t_op("row", 2'b10, 192 * 5, RC);
        t_op("word", 2'b01, 9, WC);
        t_op("page", 2'b11, 1536 * 3, PC);
        t_broken();
        t_misalign();
        t_clear_err();
        t_busy_writes();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule